// File: doc/BRIEF.md
# Bitstream to OTP Row Converter

This block turns a byte stream of FPGA configuration data into write-command records for a one-time-programmable configuration array. Bytes arrive one at a time on a valid/ready input. The block drops every byte until it sees the four-byte sync word 7E AA 99 7E. From the first byte of that word onward, it packs the stream into 8-byte rows. A row made only of zero bytes needs no programming, so the block drops it without a record. Every other row leaves the block as one record. The record holds the write opcode, a 24-bit array address and the 64 row bits.

The array is paged: each 4096-byte page holds only 328 bytes of stream data. A row's linear offset therefore maps to address floor(offset/328)*4096 + offset mod 328. The block does not divide. It keeps a slot counter inside the page that wraps at 328, and a page base that grows by 4096 on each wrap. Dropped rows still move this counter forward.

A last-byte marker on the input ends a stream. A partial final row is padded with zeros and emitted. The block then pulses `done` and is ready for a new stream with its offset back at zero. If the stream ends before a sync word is found, the block raises an error flag instead of emitting records.

Top module: `otp_row_packer`

## Requirements
- R1: Bytes accepted before the first complete 7E AA 99 7E sequence produce no record. Offset 0 is the first byte of that sequence, so the first row starts with 7E AA 99 7E. This holds even when the sequence ends on the last byte of the stream.
- R2: A row is 8 consecutive bytes from offset 8k. The earliest byte of the row occupies `out_data[63:56]` and the latest occupies `out_data[7:0]`.
- R3: When `in_last` arrives before a row is complete, the missing bytes of that row are taken as 0x00 and the row is treated as complete.
- R4: A row whose 64 bits are all zero produces no record, but its 8 bytes still count toward the offset of the rows after it.
- R5: `out_addr` equals floor(offset/328)*4096 + (offset mod 328), where offset is the row's first-byte offset.
- R6: Every record presents `out_opcode` = 0x02.
- R7: `out_valid` stays high, and `out_addr` and `out_data` stay unchanged, until `out_ready` is seen high at a clock edge. `in_ready` is low while a record is held.
- R8: A stream whose last byte arrives with no sync sequence found emits no record and sets `err_nosync`. The flag stays high until the first byte of the next stream is accepted.
- R9: After the last byte is accepted and the final record, if any, has been taken, `done` is high for exactly one cycle. The next stream then hunts for a new sync word, and its offsets start from zero again.
- R10: After reset, `out_valid`, `done` and `err_nosync` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| out_valid | output | 1 | A record is held on the outputs |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Write opcode of the record |
| out_addr | output | 24 | Paged array address |
| out_data | output | 64 | Row bytes, earliest byte in the top bits |
| done | output | 1 | One-cycle end-of-stream pulse |
| err_nosync | output | 1 | Stream ended without a sync word |

## Verification
A record becomes visible in the cycle after the clock edge that accepts the byte completing its row. In that same cycle `in_ready` falls. After the edge where `out_ready` is seen high, `out_valid` clears. `done` is high in the cycle after the edge that takes the final record, or the edge that accepts the last byte when no record is pending. `err_nosync` is already set in that cycle. The bench drives all inputs and samples all outputs at the falling edge. A handshake is predicted from the values just driven and the registered `out_valid`. So every comparison reads state settled by the previous rising edge and matches the cycle counts above.

// File: rtl/otp_pack_pkg.sv
package otp_pack_pkg;

  localparam logic [31:0] SYNC_WORD = 32'h7EAA997E;
  localparam int          SYNC_LEN  = 4;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_FILL = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;

  // Advance an in-page slot by one row; the span is a whole number of rows.
  function automatic int next_slot(input int cur, input int step, input int span);
    return (cur + step >= span) ? 0 : cur + step;
  endfunction

  // True when the next row would leave the current page.
  function automatic logic slot_wraps(input int cur, input int step, input int span);
    return (cur + step >= span);
  endfunction

endpackage

// File: rtl/sync_hunter.sv
module sync_hunter
  import otp_pack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] in_byte,
  output logic       hit
);
  localparam int HIST_W = (SYNC_LEN - 1) * 8;

  logic [HIST_W-1:0] hist_q;

  assign hit = take && ({hist_q, in_byte} == SYNC_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (clr) begin
      hist_q <= '0;
    end else if (take) begin
      hist_q <= {hist_q[HIST_W-9:0], in_byte};
    end
  end
endmodule

// File: rtl/row_builder.sv
module row_builder
  import otp_pack_pkg::*;
#(
  parameter int ROW_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   take,
  input  logic [7:0]             in_byte,
  input  logic                   last,
  input  logic                   preload,
  output logic                   emit,
  output logic [ROW_BYTES*8-1:0] row_out,
  output logic                   row_zero
);
  localparam int DW = ROW_BYTES * 8;
  localparam int CW = $clog2(ROW_BYTES);
  localparam logic [DW-1:0] SYNC_ROW = {SYNC_WORD, {(DW-32){1'b0}}};

  logic [DW-1:0] acc_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] merged;

  function automatic logic [DW-1:0] put_byte(input logic [DW-1:0] r,
                                             input logic [CW-1:0] idx,
                                             input logic [7:0]    b);
    logic [DW-1:0] o;
    o = r;
    o[(ROW_BYTES - 1 - int'(idx)) * 8 +: 8] = b;
    return o;
  endfunction

  assign merged   = put_byte(acc_q, cnt_q, in_byte);
  assign emit     = (take && ((cnt_q == CW'(ROW_BYTES - 1)) || last)) || (preload && last);
  assign row_out  = preload ? SYNC_ROW : merged;
  assign row_zero = (row_out == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (preload && !last) begin
      acc_q <= SYNC_ROW;
      cnt_q <= CW'(SYNC_LEN);
    end else if (emit) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= merged;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import otp_pack_pkg::*;
#(
  parameter int ROW_BYTES   = 8,
  parameter int PAGE_SPAN   = 328,
  parameter int PAGE_STRIDE = 4096,
  parameter int ADDR_W      = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              wrap
);
  localparam int PW = $clog2(PAGE_SPAN);

  logic [PW-1:0]     slot_q;
  logic [ADDR_W-1:0] base_q;

  assign wrap = step && slot_wraps(int'(slot_q), ROW_BYTES, PAGE_SPAN);
  assign addr = base_q + ADDR_W'(slot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      base_q <= '0;
    end else if (clr) begin
      slot_q <= '0;
      base_q <= '0;
    end else if (step) begin
      slot_q <= PW'(next_slot(int'(slot_q), ROW_BYTES, PAGE_SPAN));
      if (wrap) base_q <= base_q + ADDR_W'(PAGE_STRIDE);
    end
  end
endmodule

// File: rtl/otp_row_packer.sv
module otp_row_packer
  import otp_pack_pkg::*;
#(
  parameter int          ROW_BYTES   = 8,
  parameter int          PAGE_SPAN   = 328,
  parameter int          PAGE_STRIDE = 4096,
  parameter int          ADDR_W      = 24,
  parameter logic [7:0]  WRITE_OP    = 8'h02
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_byte,
  input  logic                   in_last,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_opcode,
  output logic [ADDR_W-1:0]      out_addr,
  output logic [ROW_BYTES*8-1:0] out_data,
  output logic                   done,
  output logic                   err_nosync
);
  localparam int DW = ROW_BYTES * 8;

  phase_e phase_q;

  // named internal events, observed by the bound checker
  logic              hunting;
  logic              take;
  logic              sync_hit;
  logic              row_emit;
  logic              row_zero;
  logic              page_wrap;
  logic              restart;
  logic [ADDR_W-1:0] map_addr;
  logic [DW-1:0]     row_bits;

  assign hunting  = (phase_q == PH_HUNT);
  assign in_ready = (phase_q != PH_FIN) && !out_valid;
  assign take     = in_valid && in_ready;
  assign restart  = (phase_q == PH_FIN) && !out_valid;
  assign done     = restart;

  sync_hunter u_hunt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .take    (take && hunting),
    .in_byte (in_byte),
    .hit     (sync_hit)
  );

  row_builder #(.ROW_BYTES(ROW_BYTES)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (restart),
    .take     (take && (phase_q == PH_FILL)),
    .in_byte  (in_byte),
    .last     (in_last),
    .preload  (sync_hit),
    .emit     (row_emit),
    .row_out  (row_bits),
    .row_zero (row_zero)
  );

  page_mapper #(
    .ROW_BYTES   (ROW_BYTES),
    .PAGE_SPAN   (PAGE_SPAN),
    .PAGE_STRIDE (PAGE_STRIDE),
    .ADDR_W      (ADDR_W)
  ) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .step  (row_emit),
    .addr  (map_addr),
    .wrap  (page_wrap)
  );

  assign out_opcode = WRITE_OP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_HUNT;
      err_nosync <= 1'b0;
    end else begin
      if (take && hunting) err_nosync <= in_last && !sync_hit;
      unique case (phase_q)
        PH_HUNT: if (take && (sync_hit || in_last)) phase_q <= in_last ? PH_FIN : PH_FILL;
        PH_FILL: if (take && in_last) phase_q <= PH_FIN;
        PH_FIN:  if (restart) phase_q <= PH_HUNT;
        default: phase_q <= PH_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (row_emit && !row_zero) begin
      out_valid <= 1'b1;
      out_addr  <= map_addr;
      out_data  <= row_bits;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/otp_row_packer_chk.sv
module otp_row_packer_chk #(
  parameter int PAGE_SPAN   = 328,
  parameter int PAGE_STRIDE = 4096,
  parameter int ADDR_W      = 24,
  parameter int ROW_BYTES   = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [ADDR_W-1:0]      out_addr,
  input logic [ROW_BYTES*8-1:0] out_data,
  input logic                   done,
  input logic                   err_nosync,
  input logic                   sync_hit,
  input logic                   row_emit,
  input logic                   page_wrap,
  input logic                   hunting,
  input logic [ADDR_W-1:0]      map_addr
);
  // R7
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4
  nonzero_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data != '0);

  // R5
  in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_addr) % PAGE_STRIDE) < PAGE_SPAN);

  // R5
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_wrap |=> (int'(map_addr) % PAGE_STRIDE) == 0);

  // R1
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunting && !sync_hit |-> !row_emit);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R8
  nosync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_nosync |-> !out_valid);
endmodule

bind otp_row_packer otp_row_packer_chk #(
  .PAGE_SPAN   (PAGE_SPAN),
  .PAGE_STRIDE (PAGE_STRIDE),
  .ADDR_W      (ADDR_W),
  .ROW_BYTES   (ROW_BYTES)
) u_chk (.*);

// File: tb/otp_row_packer_bench.sv
module otp_row_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_last;
  logic [7:0]  in_byte;
  logic        out_valid, out_ready;
  logic [7:0]  out_opcode;
  logic [23:0] out_addr;
  logic [63:0] out_data;
  logic        done, err_nosync;

  always #4 clk = ~clk;

  otp_row_packer u_otp_row_packer (.*);

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  stim[$];
  logic [23:0] exp_a[$];
  logic [63:0] exp_d[$];
  bit          exp_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_addr(input int off);
    return 24'((off / 328) * 4096 + (off % 328));
  endfunction

  task automatic build_expect();
    int origin = -1;
    exp_a.delete();
    exp_d.delete();
    for (int i = 0; i + 3 < stim.size(); i++) begin
      if (origin < 0 && stim[i] == 8'h7E && stim[i+1] == 8'hAA &&
          stim[i+2] == 8'h99 && stim[i+3] == 8'h7E) origin = i;
    end
    exp_err = (origin < 0);
    if (origin < 0) return;
    for (int pos = origin; pos < stim.size(); pos += 8) begin
      logic [63:0] row = '0;
      for (int k = 0; k < 8; k++)
        if (pos + k < stim.size()) row[63 - 8*k -: 8] = stim[pos + k];
      if (row != '0) begin
        exp_a.push_back(ref_addr(pos - origin));
        exp_d.push_back(row);
      end
    end
  endtask

  task automatic push_sync();
    stim.push_back(8'h7E); stim.push_back(8'hAA);
    stim.push_back(8'h99); stim.push_back(8'h7E);
  endtask

  task automatic run_stream(input string tag, input int rdy_pct, input int vld_pct);
    int          idx = 0;
    int          cyc = 0;
    bit          got_done = 0;
    bit          held = 0;
    logic [23:0] h_a = '0;
    logic [63:0] h_d = '0;
    build_expect();
    while (!got_done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = ($urandom_range(99) < rdy_pct);
      if (out_valid) chk(!in_ready, "R7", "in_ready while record held", 96'(in_ready), 96'(0));
      if (held) chk(out_valid && out_addr == h_a && out_data == h_d, "R7", "held record changed",
                    {out_addr, out_data}, {h_a, h_d});
      if (out_valid && out_ready) begin
        held = 0;
        if (exp_a.size() == 0) begin
          chk(0, tag, "unexpected record", {out_addr, out_data}, 96'(0));
        end else begin
          logic [23:0] ea = exp_a.pop_front();
          logic [63:0] ed = exp_d.pop_front();
          chk(out_addr == ea, "R5", "address", 96'(out_addr), 96'(ea));
          chk(out_data == ed, tag, "row data (R2)", 96'(out_data), 96'(ed));
          chk(out_opcode == 8'h02, "R6", "opcode", 96'(out_opcode), 96'(8'h02));
        end
      end else begin
        held = out_valid;
        h_a  = out_addr;
        h_d  = out_data;
      end
      if (done) begin
        got_done = 1;
        chk(exp_a.size() == 0, tag, "records left at done (R9)", 96'(exp_a.size()), 96'(0));
        chk(err_nosync == exp_err, "R8", "no-sync flag at done", 96'(err_nosync), 96'(exp_err));
        @(negedge clk);
        chk(!done, "R9", "done longer than one cycle", 96'(done), 96'(0));
        chk(in_ready, "R9", "ready for next stream", 96'(in_ready), 96'(1));
      end
      if (!got_done && idx < stim.size()) begin
        in_valid = ($urandom_range(99) < vld_pct);
        in_byte  = stim[idx];
        in_last  = (idx == stim.size() - 1);
        if (in_valid && in_ready) idx++;
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
    end
    if (!got_done) chk(0, "R9", "done never seen", 96'(0), 96'(1));
    in_valid  = 1'b0;
    in_last   = 1'b0;
    out_ready = 1'b0;
  endtask

  task automatic make_random(input int pre, input int blocks);
    stim.delete();
    for (int i = 0; i < pre; i++) stim.push_back(8'($urandom_range(255)));
    push_sync();
    for (int b = 0; b < blocks; b++) begin
      bit zero_blk = ($urandom_range(99) < 35);
      for (int k = 0; k < 8; k++)
        stim.push_back(zero_blk ? 8'h00 : 8'($urandom_range(255)));
    end
    for (int k = 0; k < int'($urandom_range(7)); k++) stim.push_back(8'($urandom_range(255)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_byte = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!out_valid, "R10", "out_valid after reset", 96'(out_valid), 96'(0));
    chk(!done, "R10", "done after reset", 96'(done), 96'(0));
    chk(!err_nosync, "R10", "err_nosync after reset", 96'(err_nosync), 96'(0));
    chk(in_ready, "R10", "in_ready after reset", 96'(in_ready), 96'(1));

    // R3: padded partial row after garbage
    stim = '{8'h01, 8'h02, 8'h03};
    push_sync();
    stim.push_back(8'hAB); stim.push_back(8'hCD);
    run_stream("R3", 60, 80);

    // R1: sync word ends on the last byte
    stim = '{8'h11, 8'h22};
    push_sync();
    run_stream("R1", 100, 100);

    // R4: forty zero rows, next row lands on page two
    stim.delete();
    push_sync();
    stim.push_back(8'h01); stim.push_back(8'h02); stim.push_back(8'h03); stim.push_back(8'h04);
    for (int i = 0; i < 320; i++) stim.push_back(8'h00);
    for (int i = 0; i < 8; i++) stim.push_back(8'h55);
    run_stream("R4", 50, 100);

    // R8: no sync word at all
    stim.delete();
    for (int i = 0; i < 20; i++) stim.push_back(8'($urandom_range(8'h7D)));
    run_stream("R8", 100, 100);

    // R9: restart after error, then random multi-page streams
    make_random(5, 30);
    run_stream("R9", 70, 90);
    make_random(17, 200);
    run_stream("R2", 40, 70);
    make_random(0, 170);
    run_stream("R5", 100, 100);
    make_random(9, 130);
    run_stream("R5", 25, 50);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule